// File: doc/BRIEF.md
# Triggered One-Shot Delayed Pulse Timer

This block is a 16-bit up-counting timer that emits a single output pulse some programmable number of clock cycles after an external trigger. Software first writes two compare values while the timer is halted. The first value sets the delay. The second sets the delay plus the pulse width. Software then sets the run bit, and the counter waits for a rising edge on the trigger pin.

Once the trigger arrives, the counter climbs from zero. The timer output flip-flop inverts on each compare match whose toggle enable is set, so the output is high from the delay value up to the delay-plus-width value. Each match also raises its own one-cycle interrupt strobe.

A software-start mode is also available, in which counting begins as soon as the run bit is set. Clearing the run bit stops the counter, clears it, and arms the block for the next trigger edge. The timer output keeps its level while the counter is stopped.

Register map, written through `wr_en`/`wr_addr`/`wr_data`:

| Address | Content |
|---|---|
| 0 | bit 0: run |
| 1 | bit 0: start mode (1 = trigger edge, 0 = software), bit 1: toggle enable for compare A, bit 2: toggle enable for compare B |
| 2 | compare A (delay) |
| 3 | compare B (delay plus width) |

Top module: `oneshot_pulse_timer`

## Requirements
- R1: After reset, `tmr_out`, `irq0` and `irq1` are 0.
- R2: In trigger mode (address 1, bit 0 = 1) with run = 1, the counter stays at 0 until a rising edge on `trig_in`. The edge passes through two synchronizer flops and is detected in the following cycle, and the counter takes the value 0 in the cycle after that. As a result, a match at compare A shows at `tmr_out` after the 4+A-th rising clock edge that follows the trigger rise.
- R3: With both toggle enables set, `tmr_out` inverts once when the counter equals compare A and once when it equals compare B, giving a pulse of B-A cycles.
- R4: `irq0` and `irq1` each pulse high for exactly one cycle per match on compare A and compare B respectively, in the same cycle as the matching output toggle.
- R5: Writing 0 to run stops and clears the counter and re-arms the block for a new trigger edge. `tmr_out` holds its level while run is 0.
- R6: Writes to addresses 1, 2 and 3 are ignored while run is 1.
- R7: A compare whose toggle enable bit is 0 does not toggle `tmr_out`, but it still raises its interrupt strobe.
- R8: A counter that is not stopped wraps from 0xFFFF to 0 and keeps counting, so each match recurs every 65536 cycles.
- R9: In software mode (address 1, bit 0 = 0), counting starts in the cycle after run is written to 1. A match at compare A shows at `tmr_out` after the (2+A)-th rising edge, counting the edge that takes the write as the first.
- R10: Trigger edges that arrive while the counter is already counting do not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| trig_in | input | 1 | External start trigger, asynchronous |
| tmr_out | output | 1 | Timer output flip-flop |
| irq0 | output | 1 | Compare A match strobe |
| irq1 | output | 1 | Compare B match strobe |

## Verification
A counter that starts early or late, or a wrong synchronizer depth, moves both edges of the pulse. The bench sees this at `tmr_out` on the exact cycle it predicts from the trigger rise. A stale start flag, or a counter that is not cleared when run drops, appears only on the next arming, as a pulse edge at the wrong offset or an output toggle in the wrong direction. A write that slips through while running changes the delay of the very next pulse. A wrap fault stays hidden until 65536 cycles after the first match, so one long run covers it.

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              trig_in,
  output logic              tmr_out,
  output logic              irq0,
  output logic              irq1
);
  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CMPA = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CMPB = ADDR_W'(3);

  logic             run_q, mode_q, started_q;
  logic [1:0]       tog_q;
  logic [CNT_W-1:0] cmpa_q, cmpb_q, cnt_q;
  logic [2:0]       trig_s;
  logic             out_q, irq0_q, irq1_q;

  wire cfg_ok    = wr_en & ~run_q;
  wire trig_rise = trig_s[1] & ~trig_s[2];
  wire active    = run_q & (started_q | ~mode_q);
  wire hit_a     = active & (cnt_q == cmpa_q);
  wire hit_b     = active & (cnt_q == cmpb_q);
  wire flip      = (hit_a & tog_q[0]) ^ (hit_b & tog_q[1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trig_s <= '0;
    else        trig_s <= {trig_s[1:0], trig_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      tog_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_RUN) run_q <= wr_data[0];
      if (cfg_ok && wr_addr == A_CFG) begin
        mode_q <= wr_data[0];
        tog_q  <= wr_data[2:1];
      end
      if (cfg_ok && wr_addr == A_CMPA) cmpa_q <= wr_data;
      if (cfg_ok && wr_addr == A_CMPB) cmpb_q <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     started_q <= 1'b0;
    else if (!run_q)                started_q <= 1'b0;
    else if (mode_q && trig_rise)   started_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt_q <= '0;
    else if (!run_q) cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_q  <= 1'b0;
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      out_q  <= out_q ^ flip;
      irq0_q <= hit_a;
      irq1_q <= hit_b;
    end

  assign tmr_out = out_q;
  assign irq0    = irq0_q;
  assign irq1    = irq1_q;
endmodule

// File: rtl/oneshot_pulse_timer_chk.sv
module oneshot_pulse_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             mode,
  input logic             started,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmpa,
  input logic [CNT_W-1:0] cmpb,
  input logic             tmr_out,
  input logic             irq0,
  input logic             irq1
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!tmr_out && !irq0 && !irq1));

  // R2
  armed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode && !started) |=> (cnt == '0));

  // R3
  toggle_has_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_out != $past(tmr_out)) |-> (irq0 || irq1));

  // R4
  irq0_single_chk: assert property (@(posedge clk) disable iff (!rst_n) irq0 |=> !irq0);

  // R4
  irq1_single_chk: assert property (@(posedge clk) disable iff (!rst_n) irq1 |=> !irq1);

  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(tmr_out) && cnt == '0 && !irq0 && !irq1));

  // R6
  cmp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(cmpa) && $stable(cmpb) && $stable(mode)));

  // R10
  started_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && started) |=> started);
endmodule

bind oneshot_pulse_timer oneshot_pulse_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .mode(mode_q), .started(started_q),
  .cnt(cnt_q), .cmpa(cmpa_q), .cmpb(cmpb_q), .tmr_out(tmr_out),
  .irq0(irq0), .irq1(irq1)
);

// File: tb/oneshot_pulse_timer_tb.sv
module oneshot_pulse_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, trig_in = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic tmr_out, irq0, irq1;
  int total = 0, bad = 0;
  int r1, f1, r2, ia, na, ib, nb;

  always #4 clk = ~clk;

  oneshot_pulse_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_in(trig_in), .tmr_out(tmr_out), .irq0(irq0), .irq1(irq1));

  // {delay, width}
  localparam logic [31:0] VEC [0:3] = '{
    {16'd0, 16'd1}, {16'd5, 16'd3}, {16'd20, 16'd1}, {16'd2, 16'd40}};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int d, input int p, input int cfg);
    wr(2'd2, 16'(d));
    wr(2'd3, 16'(d + p));
    wr(2'd1, 16'(cfg));
  endtask

  task automatic halt();
    wr(2'd0, 16'd0);
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // index 0 = current negedge; index i = after i-th following posedge
  task automatic mon(input bit do_trig, input bit retrig, input int limit);
    logic prev;
    prev = tmr_out;
    r1 = -1; f1 = -1; r2 = -1; ia = -1; na = 0; ib = -1; nb = 0;
    if (do_trig) trig_in = 1'b1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (retrig && i == 6) trig_in = 1'b0;
      if (retrig && i == 8) trig_in = 1'b1;
      if (!prev && tmr_out) begin
        if (r1 < 0) r1 = i; else if (r2 < 0) r2 = i;
      end
      if (prev && !tmr_out && f1 < 0) f1 = i;
      if (irq0) begin na++; if (ia < 0) ia = i; end
      if (irq1) begin nb++; if (ib < 0) ib = i; end
      prev = tmr_out;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tmr_out", int'(tmr_out), 0);
    check("R1 irq0", int'(irq0), 0);
    check("R1 irq1", int'(irq1), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 vector table
    for (int v = 0; v < 4; v++) begin
      int d, p;
      d = int'(VEC[v][31:16]);
      p = int'(VEC[v][15:0]);
      setup(d, p, 7);
      wr(2'd0, 16'd1);
      repeat (10) @(negedge clk);
      check("R2 idle before trigger", int'(tmr_out), 0);
      mon(1'b1, 1'b0, d + p + 12);
      check("R2 rise cycle", r1, 4 + d);
      check("R3 fall cycle", f1, 4 + d + p);
      check("R4 irq0 cycle", ia, 4 + d);
      check("R4 irq0 count", na, 1);
      check("R4 irq1 cycle", ib, 4 + d + p);
      check("R4 irq1 count", nb, 1);
      halt();
    end

    // R6 writes ignored while running
    setup(5, 3, 7);
    wr(2'd0, 16'd1);
    wr(2'd2, 16'd30);
    wr(2'd3, 16'd1);
    wr(2'd1, 16'd0);
    mon(1'b1, 1'b0, 25);
    check("R6 rise with old compare", r1, 9);
    check("R6 fall with old compare", f1, 12);
    halt();

    // R10 retrigger ignored
    setup(10, 10, 7);
    wr(2'd0, 16'd1);
    mon(1'b1, 1'b1, 35);
    check("R10 rise not restarted", r1, 14);
    check("R10 fall not restarted", f1, 24);
    check("R10 irq0 count", na, 1);
    halt();

    // R9 software start: write taken at posedge 1
    setup(3, 2, 6);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'd1;
    mon(1'b0, 1'b0, 15);
    check("R9 rise cycle", r1, 2 + 3);
    check("R9 fall cycle", f1, 2 + 3 + 2);
    halt();

    // R5 stop mid-pulse holds level, then re-arm
    setup(3, 50, 7);
    wr(2'd0, 16'd1);
    mon(1'b1, 1'b0, 12);
    check("R5 pulse high before stop", int'(tmr_out), 1);
    halt();
    begin
      int changes;
      changes = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (!tmr_out || irq1) changes++;
      end
      check("R5 level held while stopped", changes, 0);
    end
    wr(2'd0, 16'd1);
    mon(1'b1, 1'b0, 12);
    check("R5 re-armed counter from zero", f1, 7);
    halt();

    // R7 only compare B toggles
    setup(4, 6, 5);
    wr(2'd0, 16'd1);
    mon(1'b1, 1'b0, 25);
    check("R7 rise only at compare B", r1, 14);
    check("R7 irq0 still fires", ia, 8);
    check("R7 no fall", f1, -1);
    halt();
    check("R7 level kept after stop", int'(tmr_out), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 output cleared by reset", int'(tmr_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 wrap
    setup(2, 3, 7);
    wr(2'd0, 16'd1);
    mon(1'b1, 1'b0, 65536 + 20);
    check("R8 first rise", r1, 6);
    check("R8 rise after wrap", r2, 6 + 65536);
    check("R8 irq0 recurs", na, 2);
    halt();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule